// File: doc/BRIEF.md
# Sync-Marker Frame Aligner with Phase-Ambiguity Resolution

This block sits behind a symbol demodulator and works on signed soft decisions, never on hard bits. It looks for the 32-bit sync word 0x1ACFFC1D in the soft stream. The word is sent most significant bit first. The block does not know which carrier phase the upstream loop settled on, so it tests every possible rotation at once. Each rotation is a hypothesis. The hypothesis with the strongest correlation fixes two things: where the frame starts, and how to de-rotate the soft values. That same correction is then applied to every payload value that follows.

Once it has acquired, the block expects the next sync word exactly one payload length later. It strips each sync word from the output. It raises a start-of-frame flag on the first payload value. It gives up lock after three expected sync words in a row are missed.

The control is a three-state machine:
- HUNT: searching for the word.
- FRAME: forwarding payload.
- MARK: checking the expected word.

Its transitions are:
- *acquire*: HUNT→FRAME.
- *frame_done*: FRAME→MARK.
- *marker_hit* and *marker_tolerated_miss*: MARK→FRAME.
- *lock_lost*: MARK→HUNT.

Top module: `asm_frame_sync`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `locked`, `out_valid` and `out_sof` are 0.
- R2: A positive soft value means bit 1. The metric of a hypothesis sums the de-rotated soft values over the sync-word window, adding a value where the word bit is 1 and subtracting it where the bit is 0. In BPSK mode (`qpsk_mode`=0) each symbol carries one bit on `in_i`, and the window is the last 32 valid symbols. In QPSK mode each symbol carries two bits, the I value first and then the Q value, and the window is the last 16 valid symbols.
- R3: In HUNT the block acquires (moves to FRAME, `locked`=1) on the valid symbol that completes a window whose best allowed metric is strictly greater than `threshold`. A metric equal to or below `threshold` never acquires.
- R4: In BPSK mode there are two hypotheses. Hypothesis 0 passes `in_i` unchanged. Hypothesis 2 (180 degrees) negates it.
- R5: In QPSK mode there are four hypotheses, each a correction applied to (i,q):
  - h0 gives (i,q)
  - h1 gives (q,−i)
  - h2 gives (−i,−q)
  - h3 gives (−q,i)

  The largest metric wins. A tie goes to the lowest index.
- R6: Sync-word symbols are never forwarded. Each payload symbol appears on the outputs one clock after its valid input. `out_sof`=1 marks only the first payload symbol after a sync word.
- R7: After acquisition, exactly `frame_len` payload symbols (1 or more) are forwarded, and then the next sync word is expected. The locked hypothesis's correction is applied to every payload value. Negating the most negative code saturates to the most positive code.
- R8: At the end of each expected word, a metric for the locked hypothesis at or below `threshold` counts as a miss. A miss still forwards the following frame. A hit clears the miss count. The third consecutive miss drops `locked` and returns to HUNT without forwarding.
- R9: A cycle with `in_valid`=0 advances nothing, and the next cycle has `out_valid`=0.
- R10: In BPSK mode `out_q` is 0 on every forwarded symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input symbol strobe |
| in_i | input | W | Signed soft value, I rail |
| in_q | input | W | Signed soft value, Q rail (QPSK only) |
| qpsk_mode | input | 1 | 0 = BPSK, 1 = QPSK; static while locked |
| frame_len | input | LEN_W | Payload symbols between sync words |
| threshold | input | W+6 | Signed acceptance level for a metric |
| out_valid | output | 1 | Forwarded payload strobe |
| out_i | output | W | De-rotated soft value, I rail |
| out_q | output | W | De-rotated soft value, Q rail |
| out_sof | output | 1 | First payload symbol of a frame |
| locked | output | 1 | Frame alignment held |

## Verification
The bench covers these corner cases, with the failure each one would expose:
- **All four QPSK rotations, with random idle gaps.** A wrong swap or sign on one rotation would lock on the wrong hypothesis, or would de-rotate the payload into scrambled values.
- **A sync word whose metric exactly equals the threshold.** An off-by-one comparison would acquire here.
- **An inverted BPSK frame whose payload holds the most negative code.** A plain negation would wrap to the wrong sign.
- **Two misses followed by a hit, then three misses.** A miss counter that is never cleared, or that drops lock after the wrong count, would show up as a `locked` edge one frame early or late.
- **Off-by-one frame counting.** A counter error would leak sync-word symbols to the output or misplace `out_sof`.

// File: rtl/asm_fs_pkg.sv
package asm_fs_pkg;
    localparam int          MARK_BITS = 32;
    localparam logic [31:0] SYNC_WORD = 32'h1ACF_FC1D;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_FRAME,
        ST_MARK
    } fs_state_e;
endpackage

// File: rtl/asm_fs_correlator.sv
// Sliding window of soft symbols and the two base correlation sums.
// The window is evaluated on its next contents, so the symbol being
// accepted this cycle already takes part in the metric.
module asm_fs_correlator #(
    parameter int W  = 8,
    parameter int CW = W + 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_i,
    input  logic signed [W-1:0]  in_q,
    input  logic                 qpsk_mode,
    output logic signed [CW-1:0] sum_a,
    output logic signed [CW-1:0] sum_b
);
    import asm_fs_pkg::*;

    localparam int DEPTH = MARK_BITS;
    localparam int QSYMS = MARK_BITS / 2;

    logic signed [W-1:0] win_i [DEPTH];
    logic signed [W-1:0] win_q [DEPTH];
    logic signed [W-1:0] nxt_i [DEPTH];
    logic signed [W-1:0] nxt_q [DEPTH];

    // index 0 holds the newest symbol
    for (genvar k = 0; k < DEPTH; k++) begin : g_shift
        if (k == 0) begin : g_head
            assign nxt_i[k] = in_valid ? in_i : win_i[k];
            assign nxt_q[k] = in_valid ? in_q : win_q[k];
        end else begin : g_body
            assign nxt_i[k] = in_valid ? win_i[k-1] : win_i[k];
            assign nxt_q[k] = in_valid ? win_q[k-1] : win_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                win_i[k] <= '0;
                win_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                win_i[k] <= nxt_i[k];
                win_q[k] <= nxt_q[k];
            end
        end
    end

    function automatic logic signed [CW-1:0] term(input logic one,
                                                  input logic signed [W-1:0] v);
        return one ? CW'(v) : -CW'(v);
    endfunction

    logic signed [CW-1:0] bpsk_acc, qa_acc, qb_acc;

    always_comb begin
        bpsk_acc = '0;
        for (int g = 0; g < DEPTH; g++)
            bpsk_acc = bpsk_acc + term(SYNC_WORD[g], nxt_i[g]);
    end

    // symbol of age g carries word bits 2g+1 (I) and 2g (Q)
    always_comb begin
        qa_acc = '0;
        qb_acc = '0;
        for (int g = 0; g < QSYMS; g++) begin
            qa_acc = qa_acc + term(SYNC_WORD[2*g+1], nxt_i[g])
                            + term(SYNC_WORD[2*g],   nxt_q[g]);
            qb_acc = qb_acc + term(SYNC_WORD[2*g+1], nxt_q[g])
                            - term(SYNC_WORD[2*g],   nxt_i[g]);
        end
    end

    assign sum_a = qpsk_mode ? qa_acc : bpsk_acc;
    assign sum_b = qpsk_mode ? qb_acc : '0;

    // R2: in BPSK mode the quadrature sum carries no information
    assert_bpsk_no_quad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !qpsk_mode |-> sum_b == '0);
endmodule

// File: rtl/asm_fs_rotate.sv
// Phase-ambiguity correction with saturating negation.
module asm_fs_rotate #(
    parameter int W = 8
) (
    input  logic [1:0]          hyp,
    input  logic                qpsk_mode,
    input  logic signed [W-1:0] in_i,
    input  logic signed [W-1:0] in_q,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);
    localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    function automatic logic signed [W-1:0] neg_sat(input logic signed [W-1:0] v);
        return (v == MOST_NEG) ? MOST_POS : -v;
    endfunction

    always_comb begin
        if (!qpsk_mode) begin
            out_i = hyp[1] ? neg_sat(in_i) : in_i;
            out_q = '0;
        end else begin
            unique case (hyp)
                2'd0: begin out_i = in_i;          out_q = in_q;          end
                2'd1: begin out_i = in_q;          out_q = neg_sat(in_i); end
                2'd2: begin out_i = neg_sat(in_i); out_q = neg_sat(in_q); end
                2'd3: begin out_i = neg_sat(in_q); out_q = in_i;          end
            endcase
        end
    end

    // R7: saturation never yields the most negative code from a negation
    always_comb begin
        if (qpsk_mode && hyp == 2'd2)
            assert_sat_neg_R7: assert (out_i != MOST_NEG);
    end
endmodule

// File: rtl/asm_frame_sync.sv
module asm_frame_sync #(
    parameter  int W     = 8,
    parameter  int LEN_W = 12,
    localparam int CW    = W + 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [W-1:0]  in_i,
    input  logic signed [W-1:0]  in_q,
    input  logic                 qpsk_mode,
    input  logic [LEN_W-1:0]     frame_len,
    input  logic signed [CW-1:0] threshold,
    output logic                 out_valid,
    output logic signed [W-1:0]  out_i,
    output logic signed [W-1:0]  out_q,
    output logic                 out_sof,
    output logic                 locked
);
    import asm_fs_pkg::*;

    localparam int NHYP = 4;
    localparam logic [LEN_W-1:0] LAST_B = LEN_W'(MARK_BITS - 1);
    localparam logic [LEN_W-1:0] LAST_Q = LEN_W'(MARK_BITS / 2 - 1);
    localparam logic [1:0]       MISS_LIMIT = 2'd2;

    fs_state_e            state, state_nx;
    logic [LEN_W-1:0]     cnt;
    logic [1:0]           hyp, miss_cnt;
    logic signed [CW-1:0] sum_a, sum_b;
    logic signed [CW-1:0] cand [NHYP];
    logic [NHYP-1:0]      allowed;
    logic [1:0]           best_h;
    logic signed [CW-1:0] best_v;
    logic                 found;
    logic                 acquire, frame_end, mark_end, mark_hit, lose;
    logic signed [W-1:0]  fix_i, fix_q;

    asm_fs_correlator #(.W(W), .CW(CW)) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .qpsk_mode (qpsk_mode),
        .sum_a     (sum_a),
        .sum_b     (sum_b)
    );

    asm_fs_rotate #(.W(W)) u_rot (
        .hyp       (hyp),
        .qpsk_mode (qpsk_mode),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_i     (fix_i),
        .out_q     (fix_q)
    );

    // metric of every hypothesis, derived from the two base sums
    always_comb begin
        cand[0] = sum_a;
        cand[1] = sum_b;
        cand[2] = -sum_a;
        cand[3] = -sum_b;
        allowed = qpsk_mode ? 4'b1111 : 4'b0101;
    end

    // strongest allowed hypothesis, lowest index on ties
    always_comb begin
        found  = 1'b0;
        best_h = '0;
        best_v = '0;
        for (int h = 0; h < NHYP; h++) begin
            if (allowed[h] && (!found || cand[h] > best_v)) begin
                found  = 1'b1;
                best_h = 2'(h);
                best_v = cand[h];
            end
        end
    end

    assign acquire   = in_valid && (state == ST_HUNT) && (best_v > threshold);
    assign frame_end = in_valid && (state == ST_FRAME) && (cnt == frame_len - LEN_W'(1));
    assign mark_end  = in_valid && (state == ST_MARK) &&
                       (cnt == (qpsk_mode ? LAST_Q : LAST_B));
    assign mark_hit  = cand[hyp] > threshold;
    assign lose      = mark_end && !mark_hit && (miss_cnt == MISS_LIMIT);

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (acquire)   state_nx = ST_FRAME;   // acquire
            ST_FRAME: if (frame_end) state_nx = ST_MARK;    // frame_done
            ST_MARK:  if (mark_end)                         // hit, tolerated miss or lock_lost
                          state_nx = lose ? ST_HUNT : ST_FRAME;
            default:  state_nx = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // position counter, hypothesis and miss tally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            hyp      <= '0;
            miss_cnt <= '0;
        end else if (in_valid) begin
            unique case (state)
                ST_HUNT: begin
                    if (acquire) begin
                        hyp      <= best_h;
                        cnt      <= '0;
                        miss_cnt <= '0;
                    end
                end
                ST_FRAME: cnt <= frame_end ? '0 : cnt + LEN_W'(1);
                ST_MARK: begin
                    if (mark_end) begin
                        cnt      <= '0;
                        miss_cnt <= (mark_hit || lose) ? 2'd0 : miss_cnt + 2'd1;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid && (state == ST_FRAME);
            out_sof   <= in_valid && (state == ST_FRAME) && (cnt == '0);
            out_i     <= (in_valid && state == ST_FRAME) ? fix_i : '0;
            out_q     <= (in_valid && state == ST_FRAME) ? fix_q : '0;
        end
    end

    assign locked = (state != ST_HUNT);

    // ---------------- assertions ----------------
    assert_sof_marks_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    assert_data_only_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> locked);

    assert_miss_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt <= MISS_LIMIT);

    assert_drop_on_third_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(miss_cnt) == MISS_LIMIT);

    assert_idle_no_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !out_valid);

    assert_bpsk_quad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !qpsk_mode && $stable(qpsk_mode)) |-> out_q == '0);

    assert_acquire_above_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(best_v) > $past(threshold));
endmodule

// File: tb/asm_frame_sync_test.sv
module asm_frame_sync_test;
    localparam int W     = 8;
    localparam int LEN_W = 12;
    localparam int CW    = W + 6;
    localparam logic [31:0] WORD = 32'h1ACF_FC1D;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [W-1:0]  in_i = '0;
    logic signed [W-1:0]  in_q = '0;
    logic                 qpsk_mode = 1'b0;
    logic [LEN_W-1:0]     frame_len = 12'd10;
    logic signed [CW-1:0] threshold = 14'sd1200;
    logic                 out_valid, out_sof, locked;
    logic signed [W-1:0]  out_i, out_q;

    asm_frame_sync #(.W(W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .qpsk_mode(qpsk_mode), .frame_len(frame_len), .threshold(threshold),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
        .out_sof(out_sof), .locked(locked)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 0;
    bit    gap_en = 0;
    string phase = "R1 reset";

    // ---------------- behavioural reference ----------------
    int hi[$];
    int hq[$];
    int m_state = 0, m_cnt = 0, m_hyp = 0, m_miss = 0;
    int s0, s1, best, bh, mlast, ci, cq;
    int c[4];
    logic e_valid = 0, e_sof = 0, e_locked = 0;
    logic signed [W-1:0] e_i = '0, e_q = '0;

    function automatic int hist(ref int q[$], input int age);
        return (age < q.size()) ? q[age] : 0;
    endfunction

    function automatic int nsat(input int v);
        return (v == -128) ? 127 : -v;
    endfunction

    function automatic int sgn(input int bitpos);
        return WORD[bitpos] ? 1 : -1;
    endfunction

    always @(posedge clk) begin
        e_valid = 0; e_sof = 0; e_i = '0; e_q = '0;
        if (!rst_n) begin
            hi.delete(); hq.delete();
            m_state = 0; m_cnt = 0; m_hyp = 0; m_miss = 0;
        end else if (in_valid) begin
            hi.push_front(int'(in_i));
            hq.push_front(int'(in_q));
            if (hi.size() > 32) begin void'(hi.pop_back()); void'(hq.pop_back()); end
            s0 = 0; s1 = 0;
            if (!qpsk_mode) begin
                for (int j = 0; j < 32; j++) s0 += sgn(31 - j) * hist(hi, 31 - j);
            end else begin
                for (int m = 0; m < 16; m++) begin
                    s0 += sgn(31 - 2*m) * hist(hi, 15 - m) + sgn(30 - 2*m) * hist(hq, 15 - m);
                    s1 += sgn(31 - 2*m) * hist(hq, 15 - m) - sgn(30 - 2*m) * hist(hi, 15 - m);
                end
            end
            c[0] = s0; c[1] = s1; c[2] = -s0; c[3] = -s1;
            if (m_state == 0) begin
                bh = -1; best = 0;
                for (int h = 0; h < 4; h++)
                    if ((qpsk_mode || h % 2 == 0) && (bh < 0 || c[h] > best)) begin
                        bh = h; best = c[h];
                    end
                if (best > int'(threshold)) begin
                    m_state = 1; m_hyp = bh; m_cnt = 0; m_miss = 0;
                end
            end else if (m_state == 1) begin
                e_valid = 1;
                e_sof = (m_cnt == 0);
                if (!qpsk_mode) begin
                    ci = (m_hyp == 2) ? nsat(int'(in_i)) : int'(in_i); cq = 0;
                end else begin
                    case (m_hyp)
                        0: begin ci = int'(in_i);       cq = int'(in_q);       end
                        1: begin ci = int'(in_q);       cq = nsat(int'(in_i)); end
                        2: begin ci = nsat(int'(in_i)); cq = nsat(int'(in_q)); end
                        default: begin ci = nsat(int'(in_q)); cq = int'(in_i); end
                    endcase
                end
                e_i = W'(ci); e_q = W'(cq);
                if (m_cnt == int'(frame_len) - 1) begin m_state = 2; m_cnt = 0; end
                else m_cnt++;
            end else begin
                mlast = qpsk_mode ? 15 : 31;
                if (m_cnt == mlast) begin
                    m_cnt = 0;
                    if (c[m_hyp] > int'(threshold)) begin m_miss = 0; m_state = 1; end
                    else if (m_miss == 2) begin m_miss = 0; m_state = 0; end
                    else begin m_miss++; m_state = 1; end
                end else m_cnt++;
            end
        end
        e_locked = (m_state != 0);
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (out_valid !== e_valid || out_sof !== e_sof || locked !== e_locked ||
                out_i !== e_i || out_q !== e_q) begin
                errors++;
                $display("FAIL %s (R6/R7/R8 cycle match): actual v=%0b sof=%0b lk=%0b i=%0d q=%0d expected v=%0b sof=%0b lk=%0b i=%0d q=%0d",
                         phase, out_valid, out_sof, locked, out_i, out_q,
                         e_valid, e_sof, e_locked, e_i, e_q);
            end
            if (out_valid && !qpsk_mode) begin
                checks++;
                if (out_q !== '0) begin
                    errors++;
                    $display("FAIL R10 quad rail: actual %0d expected 0", out_q);
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic send_sym(input int vi, input int vq);
        if (gap_en && $urandom_range(3) == 0) begin
            @(negedge clk); in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1; in_i = W'(vi); in_q = W'(vq);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); in_valid = 1'b0;
        end
    endtask

    function automatic int noise();
        return int'($urandom_range(6)) - 3;
    endfunction

    // channel rotation applied to the clean symbol so that correction h restores it
    task automatic send_word(input int h, input int amp);
        int ti, tq, ri, rq;
        if (!qpsk_mode) begin
            for (int j = 0; j < 32; j++) begin
                ti = WORD[31 - j] ? amp : -amp;
                send_sym(h == 2 ? -ti : ti, noise());
            end
        end else begin
            for (int m = 0; m < 16; m++) begin
                ti = WORD[31 - 2*m] ? amp : -amp;
                tq = WORD[30 - 2*m] ? amp : -amp;
                case ((4 - h) % 4)
                    0: begin ri = ti;  rq = tq;  end
                    1: begin ri = tq;  rq = -ti; end
                    2: begin ri = -ti; rq = -tq; end
                    default: begin ri = -tq; rq = ti; end
                endcase
                send_sym(ri, rq);
            end
        end
    endtask

    task automatic send_payload(input bit extreme);
        for (int k = 0; k < int'(frame_len); k++) begin
            if (extreme && k == 1) send_sym(-128, -128);
            else                   send_sym(noise(), noise());
        end
    endtask

    task automatic send_frame(input int h, input int amp, input bit extreme);
        send_word(h, amp);
        send_payload(extreme);
    endtask

    task automatic send_blank_frame();
        for (int k = 0; k < (qpsk_mode ? 16 : 32); k++) send_sym(noise(), noise());
        send_payload(1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ---------------- test sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        check_bit("R1 locked in reset", locked, 1'b0);
        check_bit("R1 out_valid in reset", out_valid, 1'b0);
        check_bit("R1 out_sof in reset", out_sof, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 locked after reset", locked, 1'b0);

        // R2 / R4: BPSK, no rotation
        phase = "R2 R4 BPSK upright";
        for (int k = 0; k < 7; k++) send_sym(noise(), noise());
        send_frame(0, 60, 0);
        send_frame(0, 60, 0);
        idle(2);
        check_bit("R3 acquired upright BPSK", locked, 1'b1);

        // R8: two misses, then a hit keeps lock
        phase = "R8 tolerated misses";
        send_blank_frame();
        send_blank_frame();
        send_frame(0, 60, 0);
        idle(1);
        check_bit("R8 lock kept after two misses", locked, 1'b1);
        send_blank_frame();
        send_blank_frame();
        send_blank_frame();
        idle(2);
        check_bit("R8 lock lost after three misses", locked, 1'b0);

        // R4 / R7: inverted BPSK with extreme payload
        do_reset();
        phase = "R4 R7 BPSK inverted";
        frame_len = 12'd7;
        for (int k = 0; k < 5; k++) send_sym(noise(), noise());
        send_frame(2, 60, 1);
        send_frame(2, 60, 1);
        idle(2);
        check_bit("R4 acquired inverted BPSK", locked, 1'b1);

        // R5 / R9: QPSK, each rotation, with idle gaps
        for (int h = 0; h < 4; h++) begin
            do_reset();
            phase = $sformatf("R5 R9 QPSK rotation h%0d", h);
            qpsk_mode = 1'b1;
            frame_len = 12'd9;
            gap_en = 1'b1;
            for (int k = 0; k < 6; k++) send_sym(noise(), noise());
            send_frame(h, 60, h == 2);
            send_frame(h, 60, 0);
            send_frame(h, 60, 0);
            idle(2);
            check_bit("R5 acquired QPSK rotation", locked, 1'b1);
            gap_en = 1'b0;
        end

        // R3: metric equal to the level does not acquire, one above does
        do_reset();
        phase = "R3 threshold boundary";
        qpsk_mode = 1'b0;
        frame_len = 12'd6;
        threshold = 14'sd1920;
        send_word(0, 60);
        idle(2);
        check_bit("R3 no acquire at equal metric", locked, 1'b0);
        threshold = 14'sd1919;
        send_frame(0, 60, 0);
        idle(2);
        check_bit("R3 acquire just above level", locked, 1'b1);

        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule